// File: doc/BRIEF.md
# Floating-Point NaN Screening and Result Override Stage

This stage sits between the operand read and the register write-back of a small floating-point unit. It runs in single or double precision. For each accepted operation it inspects up to two source operands and classifies each as an ordinary number, a quiet NaN or a signaling NaN. It then decides one of three outcomes for the arithmetic result:

- write the result unchanged;
- replace the result with the default quiet NaN;
- suppress the write and raise an invalid-operation exception.

The choice depends on the operation class and on an enable bit for the invalid exception.

The polarity of the fraction MSB is the reverse of the usual convention. A set MSB marks a signaling NaN, so the default quiet NaN has that bit clear. The outcome is registered: one cycle after an accepted input the stage presents the write-back data, a write enable and a one-cycle exception pulse. A sticky invalid flag gathers exceptions until software clears it.

Top module: `fpu_nan_screen`

## Requirements
- R1: In a given precision, an operand is a NaN when its exponent field is all ones and its fraction is nonzero. The sign bit plays no part. An infinity (exponent all ones, fraction zero) counts as a number.
- R2: A NaN whose fraction MSB is 1 is signaling and one whose fraction MSB is 0 is quiet. If any examined operand is signaling in an arithmetic-class operation with `inv_en`=0, the default quiet NaN is written (`wb_en`=1) and `inv_exc` stays 0.
- R3: If any examined operand is signaling in an arithmetic-class operation with `inv_en`=1, then one cycle later `inv_exc` pulses. In that cycle `wb_en` is 0 and `wb_data` keeps its previous value.
- R4: If an arithmetic-class operation has a quiet NaN operand and no signaling one, the default quiet NaN is written and no exception is raised, whatever `inv_en` is.
- R5: The default quiet NaN is 64'h0000_0000_7FBF_FFFF when `prec_dbl`=0 and 64'h7FF7_FFFF_FFFF_FFFF when `prec_dbl`=1.
- R6: The `prec_dbl` input selects the fields:
  - `prec_dbl`=0 examines only bits [31:0]: exponent [30:23], fraction [22:0], fraction MSB bit 22. Bits [63:32] have no effect on classification.
  - `prec_dbl`=1 examines exponent [62:52] and fraction [51:0], with fraction MSB bit 51.
- R7: The `op_class` encoding:
  - 2'b00 and 2'b11 are arithmetic (screened).
  - 2'b01 is copy/absolute/negate.
  - 2'b10 is a non-floating-point result such as a compare.
  
  Classes 2'b01 and 2'b10 always write `raw_res` unchanged and never raise an exception.
- R8: Bit 0 of `src_use` enables examination of `src_a`, and bit 1 enables `src_b`. An operand whose bit is 0 does not affect the outcome.
- R9: `wb_en` and `inv_exc` are valid one cycle after `in_valid` and are 0 in any cycle not preceded by `in_valid`. `wb_data` changes only when `wb_en` is 1.
- R10: `inv_flag` is set in the same cycle as an `inv_exc` pulse. It stays set until a cycle with `flag_clr`=1 and no accepted trapping operation. A new exception in the same cycle as a clear leaves the flag set.
- R11: After reset `wb_data` is 0, and `wb_en`, `inv_exc` and `inv_flag` are 0.
- R12: An arithmetic-class operation with no NaN among its examined operands writes all 64 bits of `raw_res` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation accepted this cycle |
| prec_dbl | input | 1 | 1 = double precision, 0 = single |
| op_class | input | 2 | Operation class (see R7) |
| src_use | input | 2 | Per-operand examination enable |
| src_a | input | 64 | First source operand |
| src_b | input | 64 | Second source operand |
| raw_res | input | 64 | Raw result from the arithmetic datapath |
| inv_en | input | 1 | Invalid-operation exception enable |
| flag_clr | input | 1 | Clear the sticky invalid flag |
| wb_data | output | 64 | Write-back data |
| wb_en | output | 1 | Destination write enable |
| inv_exc | output | 1 | One-cycle invalid exception pulse |
| inv_flag | output | 1 | Sticky invalid flag |

## Verification
The hardest situation to reach from the ports is a single-precision operand whose unused upper half looks like a signaling double NaN. Uniformly random 64-bit words almost never contain an all-ones exponent, so the stimulus builds operands from chosen kinds: number, infinity, quiet NaN and signaling NaN in each precision. It also fills the bits outside the selected field with random data. Directed steps then combine a masked signaling operand, a pass-through class with the exception enabled, and a clear that coincides with a new trap. These steps check that precision, masking and class each gate the screen on their own.

// File: rtl/fpu_nan_pkg.sv
package fpu_nan_pkg;

    localparam int XLEN      = 64;
    localparam int SP_EXP_W  = 8;
    localparam int SP_FRAC_W = 23;
    localparam int DP_EXP_W  = 11;
    localparam int DP_FRAC_W = 52;
    localparam int SP_W      = SP_EXP_W + SP_FRAC_W + 1;
    localparam int DP_W      = DP_EXP_W + DP_FRAC_W + 1;
    localparam int NSRC      = 2;

    localparam logic [SP_W-1:0] SP_DFLT_QNAN = 32'h7FBF_FFFF;
    localparam logic [DP_W-1:0] DP_DFLT_QNAN = 64'h7FF7_FFFF_FFFF_FFFF;

    typedef enum logic [1:0] {
        OPC_ARITH     = 2'b00,
        OPC_XFER      = 2'b01,
        OPC_NONFP     = 2'b10,
        OPC_ARITH_ALT = 2'b11
    } opc_e;

    typedef enum logic [1:0] {
        CLS_NUM  = 2'b00,
        CLS_QNAN = 2'b01,
        CLS_SNAN = 2'b10
    } nan_cls_e;

    typedef enum logic [1:0] {
        ACT_RAW   = 2'b00,
        ACT_DQNAN = 2'b01,
        ACT_TRAP  = 2'b10
    } nan_act_e;

    typedef struct packed {
        logic [XLEN-1:0] data;
        logic            wr;
        logic            exc;
        logic            flag;
    } stage_t;

endpackage

// File: rtl/nan_field_chk.sv
module nan_field_chk #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = EXP_W + FRAC_W + 1
) (
    input  logic [W-1:0] val,
    output logic         is_nan,
    output logic         is_sig
);
    logic exp_ones;
    logic frac_nz;

    always_comb begin
        exp_ones = &val[EXP_W+FRAC_W-1:FRAC_W];
        frac_nz  = |val[FRAC_W-1:0];
        is_nan   = exp_ones & frac_nz;
        is_sig   = is_nan & val[FRAC_W-1];
    end
endmodule

// File: rtl/nan_classify.sv
module nan_classify
    import fpu_nan_pkg::*;
(
    input  logic [XLEN-1:0] op,
    input  logic            dbl,
    output nan_cls_e        cls
);
    logic sp_nan, sp_sig, dp_nan, dp_sig;
    logic sel_nan, sel_sig;

    nan_field_chk #(.EXP_W(SP_EXP_W), .FRAC_W(SP_FRAC_W)) u_sp (
        .val    (op[SP_W-1:0]),
        .is_nan (sp_nan),
        .is_sig (sp_sig)
    );

    nan_field_chk #(.EXP_W(DP_EXP_W), .FRAC_W(DP_FRAC_W)) u_dp (
        .val    (op[DP_W-1:0]),
        .is_nan (dp_nan),
        .is_sig (dp_sig)
    );

    always_comb begin
        sel_nan = dbl ? dp_nan : sp_nan;
        sel_sig = dbl ? dp_sig : sp_sig;
        if (!sel_nan)     cls = CLS_NUM;
        else if (sel_sig) cls = CLS_SNAN;
        else              cls = CLS_QNAN;
    end
endmodule

// File: rtl/nan_policy.sv
module nan_policy
    import fpu_nan_pkg::*;
#(
    parameter int N = NSRC
) (
    input  opc_e           opc,
    input  logic [N-1:0]   use_mask,
    input  logic [N-1:0]   is_q,
    input  logic [N-1:0]   is_s,
    input  logic           inv_en,
    output nan_act_e       act
);
    logic any_s, any_q, screened;

    always_comb begin
        any_s    = |(is_s & use_mask);
        any_q    = |(is_q & use_mask);
        screened = (opc == OPC_ARITH) || (opc == OPC_ARITH_ALT);
        act      = ACT_RAW;
        if (screened) begin
            if (any_s && inv_en)  act = ACT_TRAP;
            else if (any_s)       act = ACT_DQNAN;
            else if (any_q)       act = ACT_DQNAN;
        end
    end
endmodule

// File: rtl/fpu_nan_screen.sv
module fpu_nan_screen
    import fpu_nan_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic            prec_dbl,
    input  logic [1:0]      op_class,
    input  logic [1:0]      src_use,
    input  logic [63:0]     src_a,
    input  logic [63:0]     src_b,
    input  logic [63:0]     raw_res,
    input  logic            inv_en,
    input  logic            flag_clr,
    output logic [63:0]     wb_data,
    output logic            wb_en,
    output logic            inv_exc,
    output logic            inv_flag
);
    logic [XLEN-1:0] srcs [NSRC];
    logic [NSRC-1:0] is_q, is_s;
    nan_act_e        act;
    stage_t          st_d, st_q;

    assign srcs[0] = src_a;
    assign srcs[1] = src_b;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        nan_cls_e cls;
        nan_classify u_cls (
            .op  (srcs[i]),
            .dbl (prec_dbl),
            .cls (cls)
        );
        assign is_q[i] = (cls == CLS_QNAN);
        assign is_s[i] = (cls == CLS_SNAN);
    end

    nan_policy #(.N(NSRC)) u_pol (
        .opc      (opc_e'(op_class)),
        .use_mask (src_use),
        .is_q     (is_q),
        .is_s     (is_s),
        .inv_en   (inv_en),
        .act      (act)
    );

    always_comb begin
        st_d      = st_q;
        st_d.wr   = 1'b0;
        st_d.exc  = 1'b0;
        st_d.flag = st_q.flag & ~flag_clr;
        if (in_valid) begin
            unique case (act)
                ACT_RAW: begin
                    st_d.data = raw_res;
                    st_d.wr   = 1'b1;
                end
                ACT_DQNAN: begin
                    st_d.data = prec_dbl ? DP_DFLT_QNAN
                                         : {{(XLEN-SP_W){1'b0}}, SP_DFLT_QNAN};
                    st_d.wr   = 1'b1;
                end
                ACT_TRAP: begin
                    st_d.exc  = 1'b1;
                    st_d.flag = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wb_data  = st_q.data;
    assign wb_en    = st_q.wr;
    assign inv_exc  = st_q.exc;
    assign inv_flag = st_q.flag;

    // R3
    exc_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_exc |-> (!wb_en && $stable(wb_data)));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> (!wb_en && !inv_exc));

    // R9
    data_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wb_en |-> $stable(wb_data));

    // R10
    flag_follows_exc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_exc |-> inv_flag);

    // R10
    flag_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(inv_flag) |-> inv_exc);

    // R10
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flag_clr) && !inv_exc) |-> !inv_flag);

    // R7
    passthru_no_exc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op_class == 2'b01 || op_class == 2'b10)) |=> (wb_en && !inv_exc));
endmodule

// File: tb/sim_fpu_nan_screen.sv
module sim_fpu_nan_screen;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, prec_dbl = 1'b0, inv_en = 1'b0, flag_clr = 1'b0;
    logic [1:0]  op_class = 2'b00, src_use = 2'b00;
    logic [63:0] src_a = '0, src_b = '0, raw_res = '0;
    logic [63:0] wb_data;
    logic        wb_en, inv_exc, inv_flag;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [63:0] m_data = '0;
    logic        m_flag = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    fpu_nan_screen u0 (
        .clk, .rst_n, .in_valid, .prec_dbl, .op_class, .src_use,
        .src_a, .src_b, .raw_res, .inv_en, .flag_clr,
        .wb_data, .wb_en, .inv_exc, .inv_flag
    );

    // 0 number, 1 quiet, 2 signaling
    function automatic int kind_of(logic [63:0] x, logic dbl);
        if (dbl) begin
            if (x[62:52] == 11'h7FF && x[51:0] != 0) return x[51] ? 2 : 1;
        end else begin
            if (x[30:23] == 8'hFF && x[22:0] != 0) return x[22] ? 2 : 1;
        end
        return 0;
    endfunction

    function automatic logic [63:0] make_op(int k, logic dbl);
        logic [63:0] r = {$urandom, $urandom};
        if (dbl) begin
            case (k)
                1: return {r[63], 11'h7FF, 52'h0};
                2: return {r[63], 11'h7FF, 1'b0, r[50:0] | 51'h1};
                3: return {r[63], 11'h7FF, 1'b1, r[50:0]};
                default: return r;
            endcase
        end else begin
            case (k)
                1: return {r[63:32], r[31], 8'hFF, 23'h0};
                2: return {r[63:32], r[31], 8'hFF, 1'b0, r[21:0] | 22'h1};
                3: return {r[63:32], r[31], 8'hFF, 1'b1, r[21:0]};
                default: return r;
            endcase
        end
    endfunction

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step(logic v, logic dbl, logic [1:0] opc, logic [1:0] use_m,
                        logic [63:0] a, logic [63:0] b, logic [63:0] raw,
                        logic en, logic clr);
        logic e_wr = 1'b0, e_exc = 1'b0, any_s, any_q;
        string tag = "R9";
        in_valid = v; prec_dbl = dbl; op_class = opc; src_use = use_m;
        src_a = a; src_b = b; raw_res = raw; inv_en = en; flag_clr = clr;
        any_s = (use_m[0] && kind_of(a, dbl) == 2) || (use_m[1] && kind_of(b, dbl) == 2);
        any_q = (use_m[0] && kind_of(a, dbl) == 1) || (use_m[1] && kind_of(b, dbl) == 1);
        m_flag = m_flag & ~clr;
        if (v) begin
            if (opc == 2'b01 || opc == 2'b10) begin
                e_wr = 1'b1; m_data = raw; tag = "R7";
            end else if (any_s && en) begin
                e_exc = 1'b1; m_flag = 1'b1; tag = "R3";
            end else if (any_s || any_q) begin
                e_wr = 1'b1; tag = any_s ? "R2" : "R4";
                m_data = dbl ? 64'h7FF7_FFFF_FFFF_FFFF : 64'h0000_0000_7FBF_FFFF;
            end else begin
                e_wr = 1'b1; m_data = raw; tag = "R12";
            end
        end
        @(posedge clk);
        @(negedge clk);
        chk(tag, "wb_data", wb_data, m_data);
        chk(tag, "wb_en", {63'h0, wb_en}, {63'h0, e_wr});
        chk(tag, "inv_exc", {63'h0, inv_exc}, {63'h0, e_exc});
        chk("R10", "inv_flag", {63'h0, inv_flag}, {63'h0, m_flag});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11", "wb_data", wb_data, 64'h0);
        chk("R11", "outs", {61'h0, wb_en, inv_exc, inv_flag}, 64'h0);
        rst_n = 1'b1;

        // R12 plain numbers
        step(1, 1, 2'b00, 2'b11, 64'h3FF0_0000_0000_0000, 64'h4000_0000_0000_0000,
             64'h4008_0000_0000_0000, 1, 0);
        // R1 infinities are numbers, sign ignored on NaN
        step(1, 1, 2'b00, 2'b11, 64'hFFF0_0000_0000_0000, 64'h7FF0_0000_0000_0000,
             64'hDEAD_BEEF_0000_0001, 1, 0);
        step(1, 0, 2'b00, 2'b01, 64'h0000_0000_FF80_0000, 64'h0, 64'h1234_5678_9ABC_DEF0, 1, 0);
        step(1, 0, 2'b00, 2'b01, 64'h0000_0000_FF80_0001, 64'h0, 64'h1, 1, 0); // R1/R4 R5 sp
        // R2 signaling, enable off, double default R5
        step(1, 1, 2'b00, 2'b10, 64'h0, 64'hFFF8_0000_0000_0000, 64'h5, 0, 0);
        // R3 trap holds data
        step(1, 1, 2'b00, 2'b01, 64'h7FF8_0000_0000_0001, 64'h0, 64'h6, 1, 0);
        // R10 flag sticky through idle, then clear
        step(0, 0, 2'b00, 2'b00, 64'h0, 64'h0, 64'h0, 0, 0);
        step(0, 0, 2'b00, 2'b00, 64'h0, 64'h0, 64'h0, 0, 1);
        // R10 clear coincides with new trap: set wins
        step(1, 0, 2'b11, 2'b10, 64'h0, 64'h0000_0000_7FC0_0000, 64'h7, 1, 1);
        // R4 quiet with enable on
        step(1, 1, 2'b00, 2'b11, 64'h7FF0_0000_0000_0001, 64'h0, 64'h8, 1, 1);
        // R6 single ignores upper half that is a double sNaN
        step(1, 0, 2'b00, 2'b11, 64'h7FF8_0000_3F80_0000, 64'h0, 64'h9, 1, 0);
        // R6 double ignores a low word that looks like a single sNaN
        step(1, 1, 2'b00, 2'b11, 64'h3FF0_0000_7FC0_0001, 64'h0, 64'hA, 1, 0);
        // R8 masked signaling operand
        step(1, 1, 2'b00, 2'b01, 64'h1, 64'h7FF8_0000_0000_0000, 64'hB, 1, 0);
        // R7 copy and compare with sNaN and enable on
        step(1, 1, 2'b01, 2'b11, 64'h7FF8_0000_0000_0000, 64'h7FF8_0000_0000_0000, 64'hFFF8_0000_0000_0000, 1, 0);
        step(1, 0, 2'b10, 2'b11, 64'h7FC0_0000, 64'h7FC0_0000, 64'h1, 1, 0);

        for (int i = 0; i < 3000; i++) begin
            logic dbl = $urandom_range(0, 1);
            step($urandom_range(0, 4) != 0, dbl, 2'($urandom_range(0, 3)),
                 2'($urandom_range(0, 3)),
                 make_op($urandom_range(0, 3), dbl), make_op($urandom_range(0, 3), dbl),
                 {$urandom, $urandom}, $urandom_range(0, 1), $urandom_range(0, 7) == 0);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule